// File: doc/BRIEF.md
# Soft-Start and Hiccup Sequencer

This block sequences start-up and undervoltage recovery for a controller with one switching output and one linear output. It runs on the switching-cycle clock. Once both supply-ready flags are good and the active-low hold-off pin is high, it waits one step period. It then drives a 6-bit reference code up a staircase of equal steps. At the same time it decides when the switching and linear gate drivers may run, and when the undervoltage comparators are allowed to act.

An output that is already partly charged keeps its switching drivers off until the ramping reference rises past the sensed feedback. An output charged above its target keeps them off until the last step. An undervoltage on either output, once monitoring is live, shuts both outputs down together. The block then waits for one full ramp interval and starts a new ramp. This repeats until the fault is gone or the block is held off.

The states are IDLE, DELAY, RAMP, DONE and HICCUP. The transitions are:
- IDLE→DELAY when ready.
- DELAY→RAMP after one step period.
- RAMP→DONE after the last step.
- RAMP→HICCUP on a monitored undervoltage.
- DONE→HICCUP on any undervoltage.
- HICCUP→RAMP after one full ramp interval.
- Any state→IDLE when not ready.

Top module: `ss_sequencer`

## Requirements
- R1: "Ready" means por12_ok=1, por5_ok=1 and hold_off_n=1. In any cycle where ready is false, the next cycle shows IDLE: ramp_code=0 and sw_drv_en, lin_drv_en, uv_mon_en, ss_done and hiccup all 0. Leaving IDLE requires ready.
- R2: The first clock edge that sees ready in IDLE enters DELAY. DELAY lasts exactly 64 cycles with every output 0. RAMP follows with ramp_code=0 and lin_drv_en=1.
- R3: In RAMP, ramp_code starts at 0 and rises by exactly one every 64 cycles, up to 63.
- R4: uv_mon_en is 0 while ramp_code is below 16 (the first quarter of the ramp). It is 1 from step 16 onward and in DONE.
- R5: When uv_sw or uv_lin is sampled high while uv_mon_en=1, the next cycle shows HICCUP: hiccup=1, both drivers off, ramp_code=0. Undervoltage while uv_mon_en=0 is ignored.
- R6: HICCUP lasts 4096 cycles (64 steps of 64 cycles). The block then re-enters RAMP at code 0 with no extra delay. The cycle repeats while the fault persists, and ends in DONE once the fault has cleared.
- R7: In RAMP, sw_drv_en stays 0 until ref_above_fb is sampled high. From the cycle after that it stays 1 for the rest of the ramp, even if the comparator falls again.
- R8: If ref_above_fb never goes high, sw_drv_en turns on in the cycle ramp_code reaches 63.
- R9: lin_drv_en is 1 for the whole of RAMP and DONE. Both outputs follow the single shared ramp_code.
- R10: After step 63 has lasted 64 cycles, DONE holds ramp_code=63 with ss_done, uv_mon_en, sw_drv_en and lin_drv_en all 1.
- R11: Pulling hold_off_n low in any state, including HICCUP and DONE, clears all counters and outputs by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por12_ok | input | 1 | 12 V bias supply above its rising threshold |
| por5_ok | input | 1 | Internal 5.4 V rail above its rising threshold |
| hold_off_n | input | 1 | Active-low hold-off; low keeps the block idle |
| uv_sw | input | 1 | Undervoltage comparator, switching output |
| uv_lin | input | 1 | Undervoltage comparator, linear output |
| ref_above_fb | input | 1 | Ramping reference exceeds sensed feedback |
| ramp_code | output | 6 | Reference staircase code |
| sw_drv_en | output | 1 | Switching gate-driver enable |
| lin_drv_en | output | 1 | Linear pass-device enable |
| uv_mon_en | output | 1 | Undervoltage monitoring active |
| ss_done | output | 1 | Ramp finished, outputs in regulation |
| hiccup | output | 1 | Undervoltage wait in progress |

## Verification
Every output comes from registers alone, so the effect of an input sampled at a clock edge shows in the cycle after that edge. The exceptions are counted windows. RAMP begins 65 cycles after ready is first seen. Step k begins 64·k cycles later than that. DONE begins 4161 cycles after ready. A monitored undervoltage gives HICCUP one cycle later, and HICCUP hands back to RAMP 4096 cycles after it began. The driver task turns each of these counts into an absolute cycle number when it queues an expected value. The monitor compares on the falling edge of exactly that cycle, and reports an entry whose cycle has already passed as a failure.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DELAY  = 3'd1,
        ST_RAMP   = 3'd2,
        ST_DONE   = 3'd3,
        ST_HICCUP = 3'd4
    } seq_state_e;

endpackage

// File: rtl/ss_timebase.sv
// Cycle counter nested inside a step counter; shared by the start delay,
// the staircase and the hiccup wait.
module ss_timebase #(
    parameter int CYC_W  = 6,
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    output logic [STEP_W-1:0] step,
    output logic              cyc_last,
    output logic              step_last
);

    localparam logic [CYC_W-1:0]  CYC_MAX  = {CYC_W{1'b1}};
    localparam logic [STEP_W-1:0] STEP_MAX = {STEP_W{1'b1}};

    logic [CYC_W-1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc  <= '0;
            step <= '0;
        end else if (clr) begin
            cyc  <= '0;
            step <= '0;
        end else if (run) begin
            if (cyc == CYC_MAX) begin
                cyc  <= '0;
                step <= step + 1'b1;
            end else begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    assign cyc_last  = (cyc == CYC_MAX);
    assign step_last = (step == STEP_MAX);

endmodule

// File: rtl/ss_release.sv
// Latches the point where the rising reference overtakes the feedback.
module ss_release (
    input  logic clk,
    input  logic rst_n,
    input  logic in_ramp,
    input  logic ref_above_fb,
    output logic released
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            released <= 1'b0;
        end else if (!in_ramp) begin
            released <= 1'b0;
        end else if (ref_above_fb) begin
            released <= 1'b1;
        end
    end

endmodule

// File: rtl/ss_fsm.sv
module ss_fsm
    import ss_seq_pkg::*;
#(
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              uv_any,
    input  logic              cyc_last,
    input  logic              step_last,
    input  logic [STEP_W-1:0] step,
    input  logic              released,
    output logic              cnt_clr,
    output logic              cnt_run,
    output logic              in_ramp,
    output logic [STEP_W-1:0] ramp_code,
    output logic              sw_drv_en,
    output logic              lin_drv_en,
    output logic              uv_mon_en,
    output logic              ss_done,
    output logic              hiccup
);

    localparam int                NSTEPS    = 1 << STEP_W;
    localparam logic [STEP_W-1:0] MASK_STEP = STEP_W'(NSTEPS / 4);

    seq_state_e state, nxt;
    logic       mon_live;

    assign mon_live = (state == ST_RAMP) && (step >= MASK_STEP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (!ready) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   nxt = ST_DELAY;
                ST_DELAY:  if (cyc_last) nxt = ST_RAMP;
                ST_RAMP: begin
                    if (uv_any && mon_live)         nxt = ST_HICCUP;
                    else if (cyc_last && step_last) nxt = ST_DONE;
                end
                ST_DONE:   if (uv_any) nxt = ST_HICCUP;
                ST_HICCUP: if (cyc_last && step_last) nxt = ST_RAMP;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        cnt_clr    = !ready || (nxt != state);
        cnt_run    = 1'b0;
        in_ramp    = 1'b0;
        ramp_code  = '0;
        sw_drv_en  = 1'b0;
        lin_drv_en = 1'b0;
        uv_mon_en  = 1'b0;
        ss_done    = 1'b0;
        hiccup     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_DELAY:  cnt_run = 1'b1;
            ST_RAMP: begin
                cnt_run    = 1'b1;
                in_ramp    = 1'b1;
                ramp_code  = step;
                lin_drv_en = 1'b1;
                sw_drv_en  = released || step_last;
                uv_mon_en  = mon_live;
            end
            ST_DONE: begin
                ramp_code  = '1;
                lin_drv_en = 1'b1;
                sw_drv_en  = 1'b1;
                uv_mon_en  = 1'b1;
                ss_done    = 1'b1;
            end
            ST_HICCUP: begin
                cnt_run = 1'b1;
                hiccup  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ss_sequencer.sv
module ss_sequencer #(
    parameter int CYC_W  = 6,
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por12_ok,
    input  logic              por5_ok,
    input  logic              hold_off_n,
    input  logic              uv_sw,
    input  logic              uv_lin,
    input  logic              ref_above_fb,
    output logic [STEP_W-1:0] ramp_code,
    output logic              sw_drv_en,
    output logic              lin_drv_en,
    output logic              uv_mon_en,
    output logic              ss_done,
    output logic              hiccup
);

    logic              ready;
    logic              uv_any;
    logic              cnt_clr, cnt_run, in_ramp, released;
    logic              cyc_last, step_last;
    logic [STEP_W-1:0] step;

    assign ready  = por12_ok && por5_ok && hold_off_n;
    assign uv_any = uv_sw || uv_lin;

    ss_timebase #(.CYC_W(CYC_W), .STEP_W(STEP_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .run       (cnt_run),
        .step      (step),
        .cyc_last  (cyc_last),
        .step_last (step_last)
    );

    ss_release u_rel (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_ramp      (in_ramp),
        .ref_above_fb (ref_above_fb),
        .released     (released)
    );

    ss_fsm #(.STEP_W(STEP_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready      (ready),
        .uv_any     (uv_any),
        .cyc_last   (cyc_last),
        .step_last  (step_last),
        .step       (step),
        .released   (released),
        .cnt_clr    (cnt_clr),
        .cnt_run    (cnt_run),
        .in_ramp    (in_ramp),
        .ramp_code  (ramp_code),
        .sw_drv_en  (sw_drv_en),
        .lin_drv_en (lin_drv_en),
        .uv_mon_en  (uv_mon_en),
        .ss_done    (ss_done),
        .hiccup     (hiccup)
    );

endmodule

// File: rtl/ss_sequencer_chk.sv
module ss_sequencer_chk #(
    parameter int STEP_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por12_ok,
    input logic              por5_ok,
    input logic              hold_off_n,
    input logic [STEP_W-1:0] ramp_code,
    input logic              sw_drv_en,
    input logic              lin_drv_en,
    input logic              uv_mon_en,
    input logic              ss_done,
    input logic              hiccup
);

    localparam int                NSTEPS    = 1 << STEP_W;
    localparam logic [STEP_W-1:0] MASK_STEP = STEP_W'(NSTEPS / 4);
    localparam logic [STEP_W-1:0] TOP_CODE  = {STEP_W{1'b1}};

    a_r1_idle_when_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !(por12_ok && por5_ok && hold_off_n) |=>
            (ramp_code == '0 && !sw_drv_en && !lin_drv_en && !uv_mon_en && !ss_done && !hiccup));

    a_r3_code_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_code != $past(ramp_code) && ramp_code != '0) |->
            (ramp_code == STEP_W'($past(ramp_code) + 1'b1)));

    a_r4_uv_masked_early: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_done && ramp_code < MASK_STEP) |-> !uv_mon_en);

    a_r5_hiccup_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        hiccup |-> (!sw_drv_en && !lin_drv_en && ramp_code == '0));

    a_r5_hiccup_needs_monitor: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hiccup) |-> $past(uv_mon_en));

    a_r8_last_step_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_drv_en && ramp_code == TOP_CODE) |-> sw_drv_en);

    a_r10_done_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |-> (ramp_code == TOP_CODE && sw_drv_en && lin_drv_en && uv_mon_en));

endmodule

bind ss_sequencer ss_sequencer_chk #(.STEP_W(STEP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por12_ok   (por12_ok),
    .por5_ok    (por5_ok),
    .hold_off_n (hold_off_n),
    .ramp_code  (ramp_code),
    .sw_drv_en  (sw_drv_en),
    .lin_drv_en (lin_drv_en),
    .uv_mon_en  (uv_mon_en),
    .ss_done    (ss_done),
    .hiccup     (hiccup)
);

// File: tb/ss_sequencer_bench.sv
module ss_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por12_ok = 1'b0, por5_ok = 1'b0, hold_off_n = 1'b1;
    logic       uv_sw = 1'b0, uv_lin = 1'b0, ref_above_fb = 1'b0;
    logic [5:0] ramp_code;
    logic       sw_drv_en, lin_drv_en, uv_mon_en, ss_done, hiccup;

    always #5 clk = ~clk;

    ss_sequencer u_ss_sequencer (
        .clk(clk), .rst_n(rst_n), .por12_ok(por12_ok), .por5_ok(por5_ok),
        .hold_off_n(hold_off_n), .uv_sw(uv_sw), .uv_lin(uv_lin),
        .ref_above_fb(ref_above_fb), .ramp_code(ramp_code), .sw_drv_en(sw_drv_en),
        .lin_drv_en(lin_drv_en), .uv_mon_en(uv_mon_en), .ss_done(ss_done), .hiccup(hiccup)
    );

    typedef struct {
        int unsigned at;
        logic [10:0] val;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int unsigned cyc_n = 0;
    int          n_chk = 0, n_bad = 0;
    int unsigned base;

    always @(posedge clk) cyc_n <= cyc_n + 1;

    // expected-item driver: {code, sw, lin, uv, done, hiccup}
    task automatic push(input int unsigned at, input logic [5:0] code, input logic sw,
                        input logic lin, input logic uv, input logic dn, input logic hc,
                        input string tag);
        exp_t e;
        e.at  = at;
        e.val = {code, sw, lin, uv, dn, hc};
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_cyc(input int unsigned c);
        while (cyc_n < c) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc_n) begin
            logic [10:0] act;
            act = {ramp_code, sw_drv_en, lin_drv_en, uv_mon_en, ss_done, hiccup};
            n_chk++;
            if (q[0].at < cyc_n) begin
                n_bad++;
                $display("FAIL %s: missed cycle %0d (actual %b expected %b)",
                         q[0].tag, q[0].at, act, q[0].val);
            end else if (act !== q[0].val) begin
                n_bad++;
                $display("FAIL %s @%0d: actual code=%0d sw/lin/uv/done/hic=%b expected code=%0d %b",
                         q[0].tag, cyc_n, act[10:5], act[4:0], q[0].val[10:5], q[0].val[4:0]);
            end
            void'(q.pop_front());
        end
    end

    task automatic hold_and_release(input logic ref_v, input logic uvs);
        @(negedge clk);
        hold_off_n = 1'b0;
        push(cyc_n + 1, 6'd0, 0, 0, 0, 0, 0, "R11 hold-off clears");
        wait_cyc(cyc_n + 3);
        ref_above_fb = ref_v;
        uv_sw        = uvs;
        hold_off_n   = 1'b1;
        base         = cyc_n;
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push(cyc_n, 6'd0, 0, 0, 0, 0, 0, "R1 reset state");
        // only 12 V bias good: stays idle
        por12_ok = 1'b1;
        push(cyc_n + 100, 6'd0, 0, 0, 0, 0, 0, "R1 waits for 5V rail");
        wait_cyc(cyc_n + 101);

        // A: plain start, comparator already high
        ref_above_fb = 1'b1;
        por5_ok = 1'b1;
        base = cyc_n;
        push(base + 1,    6'd0,  0, 0, 0, 0, 0, "R2 delay begins");
        push(base + 64,   6'd0,  0, 0, 0, 0, 0, "R2 delay end");
        push(base + 65,   6'd0,  0, 1, 0, 0, 0, "R2/R9 ramp starts");
        push(base + 66,   6'd0,  1, 1, 0, 0, 0, "R7 release");
        push(base + 128,  6'd0,  1, 1, 0, 0, 0, "R3 step 0 holds");
        push(base + 129,  6'd1,  1, 1, 0, 0, 0, "R3 step 1");
        push(base + 1088, 6'd15, 1, 1, 0, 0, 0, "R4 still masked");
        push(base + 1089, 6'd16, 1, 1, 1, 0, 0, "R4 monitor on");
        push(base + 4097, 6'd63, 1, 1, 1, 0, 0, "R3 last step");
        push(base + 4160, 6'd63, 1, 1, 1, 0, 0, "R10 not yet done");
        push(base + 4161, 6'd63, 1, 1, 1, 1, 0, "R10 done");
        wait_cyc(base + 4170);

        // B: partial pre-charge
        hold_and_release(1'b0, 1'b0);
        push(base + 300, 6'd3, 0, 1, 0, 0, 0, "R7 drivers held");
        push(base + 301, 6'd3, 1, 1, 0, 0, 0, "R7 drivers released");
        push(base + 700, 6'd9, 1, 1, 0, 0, 0, "R7 stays released");
        wait_cyc(base + 300);
        ref_above_fb = 1'b1;
        wait_cyc(base + 600);
        ref_above_fb = 1'b0;
        wait_cyc(base + 710);

        // C: over-charged output
        hold_and_release(1'b0, 1'b0);
        push(base + 4096, 6'd62, 0, 1, 1, 0, 0, "R8 held at step 62");
        push(base + 4097, 6'd63, 1, 1, 1, 0, 0, "R8 on at last step");
        push(base + 4161, 6'd63, 1, 1, 1, 1, 0, "R10 done over-charged");
        wait_cyc(base + 4170);

        // D: undervoltage on switching output, hiccup twice, then recovery
        hold_and_release(1'b1, 1'b1);
        push(base + 1088,  6'd15, 1, 1, 0, 0, 0, "R5 UV ignored while masked");
        push(base + 1089,  6'd16, 1, 1, 1, 0, 0, "R4 monitor on");
        push(base + 1090,  6'd0,  0, 0, 0, 0, 1, "R5 shutdown");
        push(base + 5185,  6'd0,  0, 0, 0, 0, 1, "R6 wait end");
        push(base + 5186,  6'd0,  0, 1, 0, 0, 0, "R6 retry ramp");
        push(base + 6211,  6'd0,  0, 0, 0, 0, 1, "R6 repeat hiccup");
        push(base + 10307, 6'd0,  0, 1, 0, 0, 0, "R6 second retry");
        push(base + 14403, 6'd63, 1, 1, 1, 1, 0, "R6 recovered");
        wait_cyc(base + 6300);
        uv_sw = 1'b0;
        wait_cyc(base + 14410);

        // E: undervoltage on linear output while done, then hold-off in hiccup
        base = cyc_n;
        uv_lin = 1'b1;
        push(base + 1, 6'd0, 0, 0, 0, 0, 1, "R5 UV in done");
        wait_cyc(base + 10);
        hold_off_n = 1'b0;
        uv_lin = 1'b0;
        push(base + 11, 6'd0, 0, 0, 0, 0, 0, "R11 hold-off in hiccup");
        wait_cyc(base + 14);

        // F: bias flag dropped mid-ramp
        hold_off_n = 1'b1;
        base = cyc_n;
        push(base + 500, 6'd6, 1, 1, 0, 0, 0, "R3 mid-ramp");
        push(base + 501, 6'd0, 0, 0, 0, 0, 0, "R1 bias loss");
        wait_cyc(base + 500);
        por12_ok = 1'b0;
        wait_cyc(base + 505);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule